// File: doc/BRIEF.md
# Bus Memory Presence Autodetector

This block sits on an expansion card that can supply memory anywhere in a 1 MB bus address space. The space is split into sixteen 64 KB blocks. For each block it decides whether the card answers memory reads, or stays silent because memory on the motherboard already answers. Each block has a policy code. Blocks the card must serve are set to answer from reset. The top block, which holds the system firmware, is set to silent from reset. The low blocks start in a learning state.

The first read of a learning block is stretched. The block holds the bus ready line low for a fixed number of clock cycles, sized by parameters from the clock rate and a wait time of about 800 ns. During that time the card leaves the data lines alone. At the end, the byte seen on the bus is compared with the byte the card would have returned. If they are equal, other memory is present, so the block goes silent for good. If they differ, nothing else answered, so the card drives data for the rest of that cycle and answers every later read of the block. A learned code stays fixed until the next reset.

Top module: `mem_presence_detect`

## Requirements
- R1: While reset is high and on the cycle after it, `rdy_pull` and `drv_en` are both low. Reset gives block indices 0 to 9 the learning code, 10 to 14 the answer code and 15 the silent code.
- R2: A read of an answer block sets `drv_en` high at the first clock edge that sees `rd_strobe` high, and `rdy_pull` stays low.
- R3: A read of a silent block (index 15 after reset) leaves `rdy_pull` and `drv_en` low for the whole cycle.
- R4: A read of a learning block holds `rdy_pull` high for exactly WAIT_CYC clock cycles, starting at the first edge that sees `rd_strobe` high. `drv_en` stays low during that time.
- R5: If `bus_data` differs from `card_data` at the edge that ends the wait, `drv_en` rises at that edge and the block becomes an answer block.
- R6: If `bus_data` equals `card_data` at the edge that ends the wait, `drv_en` stays low and the block becomes a silent block.
- R7: Once a block has learned its code, later reads follow that code with no further wait, whatever the data, until reset. Reset puts the block back into the learning state.
- R8: `drv_en` falls at the first clock edge that sees `rd_strobe` low.
- R9: If `rd_strobe` drops before the wait ends, `rdy_pull` is released at the next edge and the block keeps its learning code.
- R10: `rdy_pull` and `drv_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_strobe | input | 1 | Memory read in progress, active high, held for the whole bus cycle |
| addr_hi | input | 4 | Address bits 19:16, which select the 64 KB block |
| bus_data | input | 8 | Byte sampled from the bus data lines |
| card_data | input | 8 | Byte the card holds for the current address |
| rdy_pull | output | 1 | High to pull the bus ready line low (insert wait states) |
| drv_en | output | 1 | Enable for the card's data drivers |

## Verification
All outputs are registered, so every result is due at the clock edge that follows the input change that causes it. For a read started at edge 1, an answer block shows `drv_en` at edge 1. A learning block shows `rdy_pull` over edges 1 to WAIT_CYC, and shows `drv_en` at edge WAIT_CYC+1 on a mismatch. The bench changes inputs on the falling edge and samples one time unit after each rising edge. It counts, edge by edge, the cycles with `rdy_pull` high and the first edge with `drv_en` high, then compares both against the counts expected for each table row and directed case.

// File: rtl/mpd_pkg.sv
package mpd_pkg;

  typedef enum logic [1:0] {
    POL_AUTO    = 2'd0,
    POL_SILENT  = 2'd1,
    POL_RESPOND = 2'd2
  } policy_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DRIVE = 2'd2,
    ST_HOLD  = 2'd3
  } fsm_t;

endpackage

// File: rtl/mpd_policy_table.sv
module mpd_policy_table
  import mpd_pkg::*;
#(
  parameter int BLK_W        = 4,
  parameter int AUTO_LAST    = 9,
  parameter int SILENT_FIRST = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BLK_W-1:0] lk_idx,
  output policy_t          lk_pol,
  input  logic             wr_en,
  input  logic [BLK_W-1:0] wr_idx,
  input  policy_t          wr_pol
);
  localparam int NUM_BLK = 2 ** BLK_W;

  policy_t tbl [NUM_BLK];

  function automatic policy_t init_pol(input int i);
    if (i <= AUTO_LAST)         return POL_AUTO;
    else if (i >= SILENT_FIRST) return POL_SILENT;
    else                        return POL_RESPOND;
  endfunction

  // An entry takes a write only while it is still learning.
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_BLK; i++) begin
      if (rst)
        tbl[i] <= init_pol(i);
      else if (wr_en && wr_idx == BLK_W'(i) && tbl[i] == POL_AUTO)
        tbl[i] <= wr_pol;
    end
  end

  assign lk_pol = tbl[lk_idx];

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_once
    // R7: a learned code never changes until reset
    p_resolve_once_r7: assert property (@(posedge clk) disable iff (rst)
      (tbl[g] != POL_AUTO) |=> $stable(tbl[g]));
  end

endmodule

// File: rtl/mpd_wait_timer.sv
module mpd_wait_timer #(
  parameter int LOAD  = 40,
  parameter int CNT_W = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(LOAD - 1);
    end else if (busy) begin
      if (abort || cnt == '0) busy <= 1'b0;
      else                    cnt  <= cnt - 1'b1;
    end
  end

  assign expire = busy && (cnt == '0);

endmodule

// File: rtl/mem_presence_detect.sv
module mem_presence_detect
  import mpd_pkg::*;
#(
  parameter int CLK_MHZ      = 50,
  parameter int WAIT_NS      = 800,
  parameter int BLK_W        = 4,
  parameter int DATA_W       = 8,
  parameter int AUTO_LAST    = 9,
  parameter int SILENT_FIRST = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_strobe,
  input  logic [BLK_W-1:0]  addr_hi,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [DATA_W-1:0] card_data,
  output logic              rdy_pull,
  output logic              drv_en
);
  localparam int WAIT_CYC = (WAIT_NS * CLK_MHZ + 999) / 1000;
  localparam int CNT_W    = $clog2(WAIT_CYC + 1);

  fsm_t             state;
  logic [BLK_W-1:0] cur_blk;
  logic [BLK_W-1:0] lk_idx;
  policy_t          lk_pol;
  policy_t          wr_pol;
  logic             wr_en;
  logic             t_start;
  logic             t_abort;
  logic             t_expire;
  logic             t_busy;
  logic             idle_rd;

  assign idle_rd = (state == ST_IDLE) && rd_strobe;
  assign lk_idx  = (state == ST_IDLE) ? addr_hi : cur_blk;
  assign t_start = idle_rd && (lk_pol == POL_AUTO);
  assign t_abort = (state == ST_WAIT) && !rd_strobe;
  assign wr_en   = (state == ST_WAIT) && rd_strobe && t_expire;
  assign wr_pol  = (bus_data == card_data) ? POL_SILENT : POL_RESPOND;

  mpd_policy_table #(
    .BLK_W(BLK_W), .AUTO_LAST(AUTO_LAST), .SILENT_FIRST(SILENT_FIRST)
  ) u_table (
    .clk(clk), .rst(rst), .lk_idx(lk_idx), .lk_pol(lk_pol),
    .wr_en(wr_en), .wr_idx(cur_blk), .wr_pol(wr_pol)
  );

  mpd_wait_timer #(.LOAD(WAIT_CYC), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .start(t_start), .abort(t_abort),
    .busy(t_busy), .expire(t_expire)
  );

  assign rdy_pull = t_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cur_blk <= '0;
      drv_en  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (rd_strobe) begin
          cur_blk <= addr_hi;
          unique case (lk_pol)
            POL_RESPOND: begin state <= ST_DRIVE; drv_en <= 1'b1; end
            POL_AUTO:    state <= ST_WAIT;
            default:     state <= ST_HOLD;
          endcase
        end
        ST_WAIT: begin
          if (!rd_strobe) state <= ST_IDLE;
          else if (t_expire) begin
            if (wr_pol == POL_RESPOND) begin
              state  <= ST_DRIVE;
              drv_en <= 1'b1;
            end else begin
              state <= ST_HOLD;
            end
          end
        end
        ST_DRIVE: if (!rd_strobe) begin state <= ST_IDLE; drv_en <= 1'b0; end
        ST_HOLD:  if (!rd_strobe) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // Checker state: length of the current ready-pull run.
  logic [CNT_W:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)           run_len <= '0;
    else if (rdy_pull) run_len <= run_len + 1'b1;
    else               run_len <= '0;
  end

  p_wait_max_r4: assert property (@(posedge clk) disable iff (rst)
    rdy_pull |-> (run_len < (CNT_W+1)'(WAIT_CYC)));

  p_drv_policy_r5: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> (lk_pol == POL_RESPOND));

  p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (idle_rd && lk_pol == POL_SILENT) |=> (!drv_en && !rdy_pull));

  p_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (drv_en && !rd_strobe) |=> !drv_en);

  p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(rdy_pull && drv_en));

endmodule

// File: tb/test_mem_presence_detect.sv
module test_mem_presence_detect;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 8;       // 100 MHz, 80 ns
  localparam int HOLD = W + 4;

  typedef struct packed {
    logic [3:0] blk;
    logic [7:0] bus;
    logic [7:0] card;
    logic [7:0] ew;   // expected ready-pull cycles
    logic [7:0] ed;   // expected first drive edge, 0 = never
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{4'hA, 8'h11, 8'h22, 8'd0, 8'd1},        // R2 answer block
    '{4'hF, 8'h33, 8'h44, 8'd0, 8'd0},        // R3 silent block
    '{4'h3, 8'h55, 8'h66, 8'(W), 8'(W+1)},    // R4 R5 mismatch
    '{4'h3, 8'h55, 8'h55, 8'd0, 8'd1},        // R5 R7 now answers
    '{4'h5, 8'h77, 8'h77, 8'(W), 8'd0},       // R4 R6 match
    '{4'h5, 8'h01, 8'h02, 8'd0, 8'd0},        // R6 R7 now silent
    '{4'h0, 8'h00, 8'hFF, 8'(W), 8'(W+1)},    // R5 lowest block
    '{4'h9, 8'hA5, 8'hA5, 8'(W), 8'd0},       // R6 highest learning block
    '{4'hE, 8'h12, 8'h12, 8'd0, 8'd1}         // R2 last answer block
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_strobe = 1'b0;
  logic [3:0] addr_hi = '0;
  logic [7:0] bus_data = '0;
  logic [7:0] card_data = '0;
  logic       rdy_pull, drv_en;

  int tests = 0;
  int fails = 0;
  int excl_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_presence_detect #(.CLK_MHZ(100), .WAIT_NS(80)) i_mem_presence_detect (
    .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .addr_hi(addr_hi),
    .bus_data(bus_data), .card_data(card_data),
    .rdy_pull(rdy_pull), .drv_en(drv_en)
  );

  always @(negedge clk) if (!rst && rdy_pull && drv_en) excl_bad++;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [3:0] blk, input logic [7:0] bus,
                         input logic [7:0] card, input int hold,
                         output int wc, output int da);
    wc = 0; da = 0;
    @(negedge clk);
    addr_hi = blk; bus_data = bus; card_data = card; rd_strobe = 1'b1;
    for (int c = 1; c <= hold; c++) begin
      @(posedge clk); #1;
      if (rdy_pull) wc++;
      if (drv_en && da == 0) da = c;
    end
    @(negedge clk);
    rd_strobe = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R1 rdy_pull in reset", int'(rdy_pull), 0);
    check("R1 drv_en in reset", int'(drv_en), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1 outputs after reset", int'(rdy_pull | drv_en), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int wc, da;
    repeat (2) @(posedge clk);
    do_reset();

    for (int i = 0; i < 9; i++) begin
      do_read(VEC[i].blk, VEC[i].bus, VEC[i].card, HOLD, wc, da);
      check($sformatf("R4/R7 wait cycles vec %0d", i), wc, int'(VEC[i].ew));
      check($sformatf("R2/R5/R6 drive edge vec %0d", i), da, int'(VEC[i].ed));
      check($sformatf("R8 drive off after strobe vec %0d", i),
            int'(drv_en | rdy_pull), 0);
    end

    // R9: strobe drops after 3 wait cycles
    @(negedge clk);
    addr_hi = 4'h2; bus_data = 8'h10; card_data = 8'h20; rd_strobe = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R9 pulling before abort", int'(rdy_pull), 1);
    @(negedge clk); rd_strobe = 1'b0;
    @(posedge clk); #1;
    check("R9 ready released on abort", int'(rdy_pull), 0);
    check("R9 no drive on abort", int'(drv_en), 0);
    do_read(4'h2, 8'h10, 8'h20, HOLD, wc, da);
    check("R9 block still learning (wait)", wc, W);
    check("R9 block still learning (drive)", da, W + 1);

    // R7 / R1: reset restores learning state of block 3 and block 5
    do_reset();
    do_read(4'h3, 8'h42, 8'h42, HOLD, wc, da);
    check("R7 block 3 relearns after reset (wait)", wc, W);
    check("R7 block 3 relearns after reset (drive)", da, 0);
    do_read(4'h5, 8'h42, 8'h43, HOLD, wc, da);
    check("R7 block 5 relearns after reset (wait)", wc, W);
    check("R7 block 5 relearns after reset (drive)", da, W + 1);
    do_read(4'hF, 8'h00, 8'h01, HOLD, wc, da);
    check("R3 firmware block silent after reset", wc + da, 0);

    check("R10 pull and drive never together", excl_bad, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule